// File: doc/BRIEF.md
# Table Pointer Byte Access Unit

This unit carries out the two groups of table-transfer instructions. Each instruction moves one byte between program memory and an 8-bit table latch. The byte is addressed through a table pointer that counts in bytes. The low nibble of the instruction word picks the direction, read or write. It also picks what happens to the pointer: it stays, it steps up after the access, it steps down after the access, or it steps up before the access. Each instruction occupies two execution cycles, and the unit drives a plain single-byte program memory port with address, read strobe, write strobe and data in both directions.

Instructions arrive on a valid/ready stream. A word is taken on a rising edge where `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, the sender must keep `ins_valid` and `ins_word` steady; a held word is stalled, never dropped. `ins_ready` is low only during the first execution cycle, so a word offered during the second cycle is taken at once. Back-to-back instructions therefore run at one every two cycles. Side-band load strobes let surrounding logic set the pointer and the latch while the unit is idle. No status flags are produced.

Top module: `tptr_unit`

## Requirements
- R1: After reset the pointer and the latch are zero, `busy` is low, `ins_ready` is high, and `mem_rd` and `mem_wr` are low.
- R2: A word is a table instruction only when bits [15:4] are zero and bit 3 is one. Bit 2 selects read (0) or write (1). Bits [1:0] select the mode: 00 keep, 01 post-increment, 10 post-decrement, 11 pre-increment. Any other word is taken and has no effect on the pointer, the latch, `busy` or the memory strobes.
- R3: For a read, `mem_rd` is high for exactly the second cycle after the accepting edge, with `mem_addr` at the effective address. The latch takes `mem_rdata` at the end of that cycle.
- R4: For a write, `mem_wr` is high for exactly the second cycle, with `mem_wdata` equal to the latch and `mem_addr` at the effective address. The latch is left unchanged.
- R5: In keep, post-increment and post-decrement modes, the effective address is the pointer value from before the instruction. Afterwards the pointer holds that value, that value plus one, or that value minus one, respectively.
- R6: In pre-increment mode, the effective address is the old pointer plus one, and the pointer ends at that value.
- R7: Pointer arithmetic wraps modulo 2^ADDR_W: 0x1FFFFF steps up to 0 and 0 steps down to 0x1FFFFF.
- R8: `busy` is high for both execution cycles, and `ins_ready` is low only in the first one. A word offered while `ins_ready` is low is taken on the first edge where ready is high, so back-to-back instructions run one every two cycles.
- R9: `ptr_load` and `lat_load` write their values on the next edge when the unit is idle. They are ignored while `busy` is high.
- R10: `mem_rd` and `mem_wr` are never high together, and neither is high outside an execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit takes the word on this edge |
| ins_word | input | 16 | Instruction word |
| busy | output | 1 | Execution in progress |
| ptr_load | input | 1 | Load pointer strobe (idle only) |
| ptr_load_val | input | ADDR_W | Value for the pointer load |
| lat_load | input | 1 | Load latch strobe (idle only) |
| lat_load_val | input | DATA_W | Value for the latch load |
| tptr | output | ADDR_W | Current table pointer |
| lat_q | output | DATA_W | Current table latch |
| mem_addr | output | ADDR_W | Program memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid in the cycle `mem_rd` is high |

## Verification
The bench builds the unit with its defaults: ADDR_W of 21 and DATA_W of 8. With these values the pointer extremes 0 and 0x1FFFFF can be loaded directly, so both wrap directions of R7 are checked in every mode. Random stimulus mixes all eight codes with random non-table words and with pointer loads near both ends of the range. Directed cases cover the stall and hand-over of a word offered while busy, and loads that arrive during execution and must be ignored.

// File: rtl/tptr_pkg.sv
package tptr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP     = 2'b00,
    MODE_POST_INC = 2'b01,
    MODE_POST_DEC = 2'b10,
    MODE_PRE_INC  = 2'b11
  } tptr_mode_e;

  typedef struct packed {
    logic       is_tbl;
    logic       is_wr;
    tptr_mode_e mode;
  } tptr_op_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FIRST  = 2'b01,
    ST_SECOND = 2'b10
  } tptr_state_e;

endpackage

// File: rtl/tptr_decode.sv
module tptr_decode
  import tptr_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic [IW-1:0] word,
  output tptr_op_t      op
);
  localparam int HI_W = IW - 4;

  logic hi_zero;

  assign hi_zero = (word[IW-1:4] == {HI_W{1'b0}});

  always_comb begin
    op.is_tbl = hi_zero && word[3];
    op.is_wr  = word[2];
    op.mode   = tptr_mode_e'(word[1:0]);
  end
endmodule

// File: rtl/tptr_seq.sv
module tptr_seq
  import tptr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ins_valid,
  input  tptr_op_t op_in,
  output logic     ins_ready,
  output logic     busy,
  output logic     step_up,
  output logic     step_down,
  output logic     mem_rd,
  output logic     mem_wr,
  output logic     lat_capture
);
  tptr_state_e state, state_nx;
  tptr_op_t    op_q;
  logic        take;

  assign ins_ready = (state != ST_FIRST);
  assign busy      = (state != ST_IDLE);
  assign take      = ins_valid && ins_ready;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE, ST_SECOND: state_nx = (take && op_in.is_tbl) ? ST_FIRST : ST_IDLE;
      ST_FIRST:           state_nx = ST_SECOND;
      default:            state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
    end else begin
      state <= state_nx;
      if (take && op_in.is_tbl) op_q <= op_in;
    end
  end

  always_comb begin
    step_up     = ((state == ST_FIRST)  && (op_q.mode == MODE_PRE_INC)) ||
                  ((state == ST_SECOND) && (op_q.mode == MODE_POST_INC));
    step_down   = (state == ST_SECOND) && (op_q.mode == MODE_POST_DEC);
    mem_rd      = (state == ST_SECOND) && !op_q.is_wr;
    mem_wr      = (state == ST_SECOND) &&  op_q.is_wr;
    lat_capture = mem_rd;
  end
endmodule

// File: rtl/tptr_pointer.sv
module tptr_pointer #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_up,
  input  logic          step_down,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load_en)   ptr <= load_val;
    else if (step_up)   ptr <= ptr + ONE;
    else if (step_down) ptr <= ptr - ONE;
  end
endmodule

// File: rtl/tptr_unit.sv
module tptr_unit
  import tptr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [15:0]       ins_word,
  output logic              busy,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_load_val,
  input  logic              lat_load,
  input  logic [DATA_W-1:0] lat_load_val,
  output logic [ADDR_W-1:0] tptr,
  output logic [DATA_W-1:0] lat_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  tptr_op_t op_dec;
  logic     step_up, step_down, lat_capture;

  tptr_decode #(.IW(16)) u_dec (
    .word (ins_word),
    .op   (op_dec)
  );

  tptr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .op_in       (op_dec),
    .ins_ready   (ins_ready),
    .busy        (busy),
    .step_up     (step_up),
    .step_down   (step_down),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .lat_capture (lat_capture)
  );

  tptr_pointer #(.AW(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (ptr_load && !busy),
    .load_val  (ptr_load_val),
    .step_up   (step_up),
    .step_down (step_down),
    .ptr       (tptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lat_q <= '0;
    else if (lat_load && !busy) lat_q <= lat_load_val;
    else if (lat_capture)       lat_q <= mem_rdata;
  end

  assign mem_addr  = tptr;
  assign mem_wdata = lat_q;
endmodule

// File: rtl/tptr_checks.sv
module tptr_checks #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              busy,
  input logic              ptr_load,
  input logic              lat_load,
  input logic [ADDR_W-1:0] tptr,
  input logic [DATA_W-1:0] lat_q,
  input logic              mem_rd,
  input logic              mem_wr
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10
  AST_STROBE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr); // R4
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R3
  AST_STALL_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !busy && (mem_rd || mem_wr)) |-> 1'b0); // R8
  AST_FIRST_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ins_ready) |=> (busy && ins_ready)); // R8
  AST_PTR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ptr_load) |=> $stable(tptr)); // R9
  AST_LAT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lat_load) |=> $stable(lat_q)); // R9
endmodule

bind tptr_unit tptr_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .busy      (busy),
  .ptr_load  (ptr_load),
  .lat_load  (lat_load),
  .tptr      (tptr),
  .lat_q     (lat_q),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/tptr_unit_test.sv
module tptr_unit_test;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ins_valid = 0;
  logic          ins_ready;
  logic [15:0]   ins_word = '0;
  logic          busy;
  logic          ptr_load = 0;
  logic [AW-1:0] ptr_load_val = '0;
  logic          lat_load = 0;
  logic [DW-1:0] lat_load_val = '0;
  logic [AW-1:0] tptr;
  logic [DW-1:0] lat_q;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] ptr_m = '0;
  logic [DW-1:0] lat_m = '0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ {3'b101, a[20:16]};
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  tptr_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_ptr(input logic [AW-1:0] v);
    @(negedge clk); ptr_load = 1; ptr_load_val = v;
    @(negedge clk); ptr_load = 0;
    ptr_m = v;
    chk(tptr == v, "R9 pointer load", 32'(tptr), 32'(v));
  endtask

  task automatic load_lat(input logic [DW-1:0] v);
    @(negedge clk); lat_load = 1; lat_load_val = v;
    @(negedge clk); lat_load = 0;
    lat_m = v;
    chk(lat_q == v, "R9 latch load", 32'(lat_q), 32'(v));
  endtask

  // Runs one table instruction from idle; optional junk loads during execution.
  task automatic run_tbl(input logic [3:0] code, input bit junk_loads);
    logic [AW-1:0] ea;
    bit wr;
    logic [1:0] md;
    wr = code[2]; md = code[1:0];
    ea = (md == 2'b11) ? ptr_m + 1'b1 : ptr_m;
    @(negedge clk); ins_valid = 1; ins_word = {12'h000, code};
    @(negedge clk); ins_valid = 0;
    // first cycle
    chk(busy && !ins_ready, "R8 first cycle busy/stall", {busy, ins_ready}, 2'b10);
    chk(!mem_rd && !mem_wr, "R10 no strobe in first cycle", {mem_rd, mem_wr}, 0);
    if (junk_loads) begin
      ptr_load = 1; ptr_load_val = ~ptr_m; lat_load = 1; lat_load_val = ~lat_m;
    end
    @(negedge clk);
    // second cycle
    chk(busy && ins_ready, "R8 second cycle", {busy, ins_ready}, 2'b11);
    chk(mem_addr == ea, md == 2'b11 ? "R6 effective address" : "R5 effective address",
        32'(mem_addr), 32'(ea));
    if (wr) begin
      chk(mem_wr && !mem_rd, "R4 write strobe", {mem_rd, mem_wr}, 2'b01);
      chk(mem_wdata == lat_m, "R4 write data", 32'(mem_wdata), 32'(lat_m));
    end else begin
      chk(mem_rd && !mem_wr, "R3 read strobe", {mem_rd, mem_wr}, 2'b10);
    end
    @(negedge clk);
    ptr_load = 0; lat_load = 0;
    if (!wr) lat_m = mem_f(ea);
    case (md)
      2'b00: ptr_m = ptr_m;
      2'b01: ptr_m = ptr_m + 1'b1;
      2'b10: ptr_m = ptr_m - 1'b1;
      default: ptr_m = ea;
    endcase
    chk(!busy && !mem_rd && !mem_wr, "R10 idle after execution", {busy, mem_rd, mem_wr}, 0);
    chk(tptr == ptr_m, junk_loads ? "R9 load ignored while busy / pointer" : "R5 R6 R7 pointer after",
        32'(tptr), 32'(ptr_m));
    chk(lat_q == lat_m, wr ? "R4 latch kept" : "R3 latch captured", 32'(lat_q), 32'(lat_m));
  endtask

  task automatic run_other(input logic [15:0] w);
    @(negedge clk); ins_valid = 1; ins_word = w;
    @(negedge clk); ins_valid = 0;
    chk(!busy && ins_ready && !mem_rd && !mem_wr, "R2 non-table word ignored",
        {busy, ins_ready, mem_rd, mem_wr}, 4'b0100);
    chk(tptr == ptr_m && lat_q == lat_m, "R2 state unchanged by non-table word",
        32'(tptr), 32'(ptr_m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    chk(tptr == 0 && lat_q == 0, "R1 reset pointer/latch", 32'(tptr), 0);
    chk(!busy && ins_ready && !mem_rd && !mem_wr, "R1 reset control",
        {busy, ins_ready, mem_rd, mem_wr}, 4'b0100);
    rst_n = 1;

    // R7 wrap corners in every mode
    load_lat(8'h5A);
    load_ptr(TOP);        run_tbl(4'hD, 0);   // post-inc write wraps to 0
    load_ptr(TOP);        run_tbl(4'hB, 0);   // pre-inc read wraps
    load_ptr('0);         run_tbl(4'hA, 0);   // post-dec read wraps to TOP
    chk(tptr == TOP, "R7 wrap down", 32'(tptr), 32'(TOP));
    load_ptr('0);         run_tbl(4'hE, 0);   // post-dec write
    run_tbl(4'h8, 0);     run_tbl(4'hC, 0);   // keep modes

    // R9 loads during execution ignored
    load_ptr(21'h012345); run_tbl(4'h9, 1);
    run_tbl(4'hF, 1);

    // R8 back-to-back hand-over
    begin
      logic [AW-1:0] ea2;
      load_ptr(21'h000100);
      @(negedge clk); ins_valid = 1; ins_word = 16'h0009;
      @(negedge clk); ins_word = 16'h0009;            // first cycle: held
      chk(!ins_ready && busy, "R8 stall while first cycle", {busy, ins_ready}, 2'b10);
      @(negedge clk);
      chk(ins_ready && mem_rd && mem_addr == 21'h000100, "R8 ready in second cycle",
          32'(mem_addr), 32'h100);
      @(negedge clk); ins_valid = 0;                  // second taken at that edge
      chk(busy && !ins_ready && tptr == 21'h000101, "R8 held word taken without gap",
          32'(tptr), 32'h101);
      ea2 = 21'h000101;
      @(negedge clk);
      chk(mem_rd && mem_addr == ea2, "R3 second read address", 32'(mem_addr), 32'(ea2));
      @(negedge clk);
      ptr_m = 21'h000102; lat_m = mem_f(ea2);
      chk(tptr == ptr_m && lat_q == lat_m, "R3 R5 back-to-back result", 32'(lat_q), 32'(lat_m));
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        logic [15:0] w;
        w = 16'($urandom);
        if (w[15:4] == 12'h000) w[3] = 1'b0;
        run_other(w);
      end else if (sel == 1) begin
        int k;
        k = $urandom_range(0, 2);
        load_ptr(k == 0 ? '0 : k == 1 ? TOP : AW'($urandom));
      end else if (sel == 2) begin
        load_lat(8'($urandom));
      end else begin
        run_tbl(4'h8 | 4'($urandom_range(0, 7)), 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule